// File: doc/BRIEF.md
# Automatic RTS/CTS Flow-Control Controller

This block sits next to a UART receive FIFO and transmitter and runs hardware handshaking without software help. On the receive side it compares the FIFO fill level with a programmable halt level and a lower resume level. It drops RTS when the fill level reaches the halt level. It raises RTS again only once the FIFO has drained to the resume level. The gap between the two levels gives hysteresis, so RTS does not toggle on every byte.

On the transmit side it passes the CTS pin through a synchronizer and gives the transmitter a start permit only while CTS is active. The transmitter asks for the permit only at the boundary before a start bit, so a character that is already on the line always completes.

Software sets up the block through a small register write port. A control register holds the two automatic-mode enables and a manual RTS bit. A threshold register holds the two levels as 4-bit fields. The halt level can be at most 60 bytes of a 64-entry FIFO, so a remote sender that misses the RTS drop still has room for at least one more byte.

Top module: `uart_flow_ctrl`

## Requirements
- R1: A write with `regAddr`=0 loads the control register: bit 7 enables auto-CTS, bit 6 enables auto-RTS, bit 0 is the manual RTS level. A write with `regAddr`=1 loads the threshold register: bits [3:0] are the halt field and bits [7:4] are the resume field, and each field times 4 gives a level in bytes. The two enables act independently.
- R2: After reset, `rtsOut` and `txPermit` are both 0. The control register and the threshold register are cleared.
- R3: With auto-RTS on, `rtsOut` goes to 0 one clock edge after `rxLevel` is greater than or equal to the halt level.
- R4: With auto-RTS on and RTS dropped, `rtsOut` returns to 1 one clock edge after `rxLevel` is less than or equal to the resume level. While the level is between the two levels, RTS keeps its previous value.
- R5: Until the threshold register is first written, the halt level is 1 byte and the resume level is 0 bytes.
- R6: Once the threshold register has been written, a halt field less than or equal to the resume field is a misconfiguration. While it lasts, the RTS state holds its value.
- R7: With auto-RTS off, `rtsOut` equals control bit 0. The automatic RTS state is cleared, so after auto-RTS is enabled RTS rises only when the level is at or below the resume level.
- R8: With auto-CTS on, `txPermit` equals `txReady` AND the synchronized CTS. A change on `ctsIn` shows at `txPermit` after two clock edges. With auto-CTS off, `txPermit` equals `txReady`.
- R9: A fill level above the halt level, up to the full FIFO depth of 64, keeps RTS at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects the control register, 1 selects the threshold register |
| regWrData | input | 8 | Register write data |
| rxLevel | input | 7 | Receive FIFO fill level in bytes (0 to 64) |
| ctsIn | input | 1 | CTS pin, active high, asynchronous |
| txReady | input | 1 | Transmitter is idle at a character boundary and has data to send |
| rtsOut | output | 1 | RTS pin, active high |
| txPermit | output | 1 | Transmitter may start a character |

## Verification
The bench walks the fill level up to the halt level and back down to the resume level. A design without hysteresis would raise RTS again as soon as the level dropped below the halt level. An off-by-one comparison would show up exactly at 16 and 8 bytes. Further corner cases are:
- the one-byte default halt level before the threshold register is written;
- an inverted threshold pair, which a faulty design would act on;
- enabling auto-RTS while the level sits between the two levels, where a design that kept stale state would raise RTS at once.

It also counts the two synchronizer edges before CTS gates the permit. A design with a missing or extra stage would change the permit one cycle early or late.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  localparam int REG_W = 8;
  localparam int CTRL_ADDR = 0;
  localparam int AUTO_CTS_BIT = 7;
  localparam int AUTO_RTS_BIT = 6;
  localparam int MANUAL_RTS_BIT = 0;

  typedef struct packed {
    logic rtsSet;
    logic rtsClr;
  } rtsStrobe_t;
endpackage

// File: rtl/flowctl_datapath.sv
module flowctl_datapath
  import flowctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int FIELD_W = 4,
  parameter int SCALE_SHIFT = 2,
  parameter int SYNC_STAGES = 2,
  localparam int LEVEL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               ctsIn,
  input  logic               txReady,
  input  rtsStrobe_t         stb,
  output logic               autoRts,
  output logic               misconfig,
  output logic               atHalt,
  output logic               atResume,
  output logic               rtsState,
  output logic               rtsOut,
  output logic               txPermit
);
  logic [REG_W-1:0]       ctrlReg;
  logic [FIELD_W-1:0]     haltFld, resumeFld;
  logic                   thrWritten;
  logic [LEVEL_W-1:0]     haltLvl, resumeLvl;
  logic [SYNC_STAGES-1:0] ctsPipe;
  logic                   ctsSync, autoCts;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      haltFld    <= '0;
      resumeFld  <= '0;
      thrWritten <= 1'b0;
    end else if (regWrEn) begin
      if (regAddr == 1'(CTRL_ADDR)) begin
        ctrlReg <= regWrData;
      end else begin
        haltFld    <= regWrData[FIELD_W-1:0];
        resumeFld  <= regWrData[2*FIELD_W-1:FIELD_W];
        thrWritten <= 1'b1;
      end
    end
  end

  assign autoRts = ctrlReg[AUTO_RTS_BIT];
  assign autoCts = ctrlReg[AUTO_CTS_BIT];

  // CTS synchronizer chain
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ctsPipe[i] <= 1'b0;
      else if (i == 0) ctsPipe[i] <= ctsIn;
      else ctsPipe[i] <= ctsPipe[(i == 0) ? 0 : i-1];
    end
  end
  assign ctsSync = ctsPipe[SYNC_STAGES-1];

  // Level compare
  assign haltLvl   = thrWritten ? (LEVEL_W'(haltFld) << SCALE_SHIFT) : LEVEL_W'(1);
  assign resumeLvl = thrWritten ? (LEVEL_W'(resumeFld) << SCALE_SHIFT) : LEVEL_W'(0);
  assign misconfig = thrWritten && (haltFld <= resumeFld);
  assign atHalt    = rxLevel >= haltLvl;
  assign atResume  = rxLevel <= resumeLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rtsState <= 1'b0;
    else if (stb.rtsClr) rtsState <= 1'b0;
    else if (stb.rtsSet) rtsState <= 1'b1;
  end

  assign rtsOut   = autoRts ? rtsState : ctrlReg[MANUAL_RTS_BIT];
  assign txPermit = txReady & (~autoCts | ctsSync);

  // R3
  a_r3_halt_clears: assert property (@(posedge clk) disable iff (!rstN)
    (autoRts && !misconfig && rtsState && rxLevel >= haltLvl) |=> !rtsState);
  // R4
  a_r4_resume_sets: assert property (@(posedge clk) disable iff (!rstN)
    (autoRts && !misconfig && !rtsState && rxLevel <= resumeLvl) |=> rtsState);
  // R6
  a_r6_misconfig_holds: assert property (@(posedge clk) disable iff (!rstN)
    (autoRts && misconfig) |=> $stable(rtsState));
  // R8
  if (SYNC_STAGES == 2) begin : g_ctsChk
    a_r8_cts_blocks: assert property (@(posedge clk) disable iff (!rstN)
      (autoCts && !$past(ctsIn) && !$past(ctsIn, 2)) |-> !txPermit);
  end
endmodule

// File: rtl/flowctl_control.sv
module flowctl_control
  import flowctl_pkg::*;
(
  input  logic       autoRts,
  input  logic       misconfig,
  input  logic       atHalt,
  input  logic       atResume,
  input  logic       rtsState,
  output rtsStrobe_t stb
);
  always_comb begin
    stb = '0;
    if (!autoRts) begin
      stb.rtsClr = 1'b1;
    end else if (!misconfig) begin
      if (rtsState && atHalt) stb.rtsClr = 1'b1;
      else if (!rtsState && atResume) stb.rtsSet = 1'b1;
    end
  end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import flowctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int FIELD_W = 4,
  parameter int SCALE_SHIFT = 2,
  parameter int SYNC_STAGES = 2,
  localparam int LEVEL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               ctsIn,
  input  logic               txReady,
  output logic               rtsOut,
  output logic               txPermit
);
  rtsStrobe_t stb;
  logic autoRts, misconfig, atHalt, atResume, rtsState;

  flowctl_datapath #(
    .FIFO_DEPTH(FIFO_DEPTH), .FIELD_W(FIELD_W),
    .SCALE_SHIFT(SCALE_SHIFT), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk, .rstN, .regWrEn, .regAddr, .regWrData, .rxLevel, .ctsIn, .txReady,
    .stb, .autoRts, .misconfig, .atHalt, .atResume, .rtsState, .rtsOut, .txPermit
  );

  flowctl_control u_ctl (
    .autoRts, .misconfig, .atHalt, .atResume, .rtsState, .stb
  );
endmodule

// File: tb/uart_flow_ctrl_test.sv
module uart_flow_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [6:0] rxLevel = '0;
  logic ctsIn = 1'b0;
  logic txReady = 1'b0;
  logic rtsOut, txPermit;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_flow_ctrl uut (
    .clk, .rstN, .regWrEn, .regAddr, .regWrData, .rxLevel, .ctsIn, .txReady,
    .rtsOut, .txPermit
  );

  // {expected rts, level}; halt 16 bytes, resume 8 bytes
  localparam logic [7:0] VEC [14] = '{
    {1'b1, 7'd0},  {1'b1, 7'd10}, {1'b1, 7'd15}, {1'b0, 7'd16},
    {1'b0, 7'd17}, {1'b0, 7'd12}, {1'b0, 7'd9},  {1'b1, 7'd8},
    {1'b1, 7'd12}, {1'b1, 7'd15}, {1'b0, 7'd16}, {1'b0, 7'd64},
    {1'b0, 7'd61}, {1'b1, 7'd0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] lvl);
    @(negedge clk);
    rxLevel = lvl;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    #1;
    regWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R2 rts after reset", rtsOut, 1'b0);
    check("R2 permit after reset", txPermit, 1'b0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R2 rts out of reset", rtsOut, 1'b0);

    // R5: default halt 1 byte, resume 0
    wr(1'b0, 8'h40);
    step(7'd0);
    check("R5 rts at level 0", rtsOut, 1'b1);
    step(7'd1);
    check("R5 halt at 1 byte", rtsOut, 1'b0);
    step(7'd0);
    check("R5 resume at 0", rtsOut, 1'b1);

    // R1 R3 R4 R9: table walk
    wr(1'b1, 8'h24);
    foreach (VEC[i]) begin
      step(VEC[i][6:0]);
      check($sformatf("R3/R4/R9 vec %0d level %0d", i, VEC[i][6:0]), rtsOut, VEC[i][7]);
    end

    // R6: misconfiguration holds
    wr(1'b1, 8'h32);
    step(7'd60);
    check("R6 hold high", rtsOut, 1'b1);
    wr(1'b1, 8'h24);
    step(7'd60);
    check("R6 valid again clears", rtsOut, 1'b0);
    wr(1'b1, 8'h33);
    step(7'd0);
    check("R6 hold low", rtsOut, 1'b0);
    wr(1'b1, 8'h24);

    // R7: manual mode, cleared state
    wr(1'b0, 8'h01);
    check("R7 manual high", rtsOut, 1'b1);
    wr(1'b0, 8'h00);
    check("R7 manual low", rtsOut, 1'b0);
    step(7'd12);
    wr(1'b0, 8'h40);
    step(7'd12);
    check("R7 enable between levels", rtsOut, 1'b0);
    step(7'd8);
    check("R7 rise at resume", rtsOut, 1'b1);

    // R8: CTS gating
    txReady = 1'b1;
    wr(1'b0, 8'h81);
    check("R1 auto-RTS off gives manual bit", rtsOut, 1'b1);
    step(7'd0); step(7'd0);
    check("R8 cts low blocks", txPermit, 1'b0);
    @(negedge clk); ctsIn = 1'b1;
    @(posedge clk); #1;
    check("R8 one edge later", txPermit, 1'b0);
    @(posedge clk); #1;
    check("R8 two edges later", txPermit, 1'b1);
    @(negedge clk); ctsIn = 1'b0;
    @(posedge clk); #1;
    check("R8 drop one edge", txPermit, 1'b1);
    @(posedge clk); #1;
    check("R8 drop two edges", txPermit, 1'b0);
    wr(1'b0, 8'h40);
    check("R1 auto-CTS off ignores cts", txPermit, 1'b1);
    @(negedge clk); txReady = 1'b0;
    #1;
    check("R8 no request no permit", txPermit, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule